// File: doc/BRIEF.md
# Accelerator Launch and Status Register Slave

This block is the register front end a processor uses to drive a fixed-function compute kernel. It sits on a 32-bit AXI4-Lite bus and holds two things. One is a small set of control and interrupt registers. The other is a bank of nine 32-bit kernel arguments: three work-group coordinates, three global offsets and three buffer addresses. The arguments go straight to the kernel on a flat output bus.

Software writes the arguments, then sets the launch bit. The block holds a start request towards the kernel until the kernel reports through its ready pulse that it has taken the job. When the kernel signals completion, a sticky completion flag is latched. Software can poll that flag or wait for the interrupt line. A relaunch mode keeps the start request asserted across accepted jobs, so the kernel runs back to back without help from software.

Top module: `accel_ctrl_slave`

## Requirements
- R1: After reset, every register reads as zero, `accel_start`, `irq`, `s_bvalid` and `s_rvalid` are low, and `kern_args` is all zero.
- R2: Argument k (k = 0..8) is read/write at byte offset 0x10 + 8*k. It appears on `kern_args[32*k +: 32]`. Each write byte lane is updated only when its strobe bit is set.
- R3: Writing 1 to bit 0 of offset 0x00 (byte lane 0) raises `accel_start`. Writing 0 there has no effect. With relaunch off, the request drops on the cycle after `accel_ready` is sampled high.
- R4: Bit 1 of offset 0x00 is set by an `accel_done` pulse and cleared when a read of offset 0x00 is accepted. If both happen in the same cycle, the bit ends up set, and that read returns the value from before the pulse.
- R5: Bit 7 of offset 0x00 is a read/write relaunch flag. While it is set, an `accel_ready` pulse leaves `accel_start` high.
- R6: Bit 2 and bit 3 of offset 0x00 return the `accel_idle` and `accel_ready` inputs as sampled in the cycle the read is accepted.
- R7: At offset 0x0C, bit 0 is the completion channel and bit 1 is the ready channel. Writing 1 to a bit toggles it. An event (`accel_done` for bit 0, `accel_ready` for bit 1) sets its bit only when the matching enable bit at offset 0x08 is 1.
- R8: `irq` is high exactly when bit 0 of offset 0x04 is 1 and at least one bit at 0x0C is 1 whose enable bit at 0x08 is also 1.
- R9: Reserved words (0x14, 0x1C, ... 0x54, and everything above 0x54) and reserved bits read as zero. Writes to them change nothing.
- R10: A write is accepted when address and data are valid together. Its OKAY response is valid on the next cycle. A read is accepted when no read data is pending, and its data with OKAY is valid on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | 7 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response (always OKAY) |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 7 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response (always OKAY) |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| accel_start | output | 1 | Launch request to the kernel |
| accel_done | input | 1 | Kernel completion pulse |
| accel_idle | input | 1 | Kernel idle level |
| accel_ready | input | 1 | Kernel accepted a launch |
| irq | output | 1 | Interrupt request, active high |
| kern_args | output | 288 | Nine packed 32-bit kernel arguments |

## Verification
The assertions assume that `accel_done` and `accel_ready` are single-cycle pulses. They also assume that the master holds a response channel's ready signal high, or keeps it low only while the valid signal waits. The bench drives every kernel indication as a one-cycle pulse between falling edges and keeps `s_bready` and `s_rready` tied high. It waits for each read response to drain before it issues the next address. Word addresses are always aligned, because the block ignores the two low address bits.

// File: rtl/accel_ctrl_pkg.sv
package accel_ctrl_pkg;
  // word indices (byte offset / 4)
  localparam int unsigned WORD_CTRL = 0;
  localparam int unsigned WORD_GIE  = 1;
  localparam int unsigned WORD_IER  = 2;
  localparam int unsigned WORD_ISR  = 3;
  localparam int unsigned WORD_ARG0 = 4;
  localparam int unsigned ARG_STEP  = 2;

  // bit positions inside the control word
  localparam int unsigned CB_START = 0;
  localparam int unsigned CB_DONE  = 1;
  localparam int unsigned CB_IDLE  = 2;
  localparam int unsigned CB_READY = 3;
  localparam int unsigned CB_AUTO  = 7;

  // interrupt channels
  localparam int unsigned N_IRQ_CH = 2;
  typedef logic [N_IRQ_CH-1:0] irq_vec_t;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/axil_port.sv
module axil_port #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned WORD_W = ADDR_W - 2,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_word,
  output logic [DATA_W-1:0] wr_data,
  output logic [STRB_W-1:0] wr_strb,
  output logic              rd_en,
  output logic [WORD_W-1:0] rd_word,
  input  logic [DATA_W-1:0] rd_word_data
);
  import accel_ctrl_pkg::*;

  logic              bvalid_q, bvalid_d;
  logic              rvalid_q, rvalid_d;
  logic [DATA_W-1:0] rdata_q,  rdata_d;

  assign wr_en   = awvalid & wvalid & ~bvalid_q;
  assign awready = wr_en;
  assign wready  = wr_en;
  assign wr_word = awaddr[ADDR_W-1:2];
  assign wr_data = wdata;
  assign wr_strb = wstrb;

  assign arready = ~rvalid_q;
  assign rd_en   = arvalid & ~rvalid_q;
  assign rd_word = araddr[ADDR_W-1:2];

  always_comb begin
    bvalid_d = bvalid_q;
    if (wr_en)                bvalid_d = 1'b1;
    else if (bvalid_q && bready) bvalid_d = 1'b0;
    rvalid_d = rvalid_q;
    rdata_d  = rdata_q;
    if (rd_en) begin
      rvalid_d = 1'b1;
      rdata_d  = rd_word_data;
    end else if (rvalid_q && rready) begin
      rvalid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      bvalid_q <= bvalid_d;
      rvalid_q <= rvalid_d;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign bvalid = bvalid_q;
  assign bresp  = RESP_OKAY;
  assign rvalid = rvalid_q;
  assign rdata  = rdata_q;
  assign rresp  = RESP_OKAY;

  AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid);  // R10
  AST_RVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata));  // R10
  AST_READ_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid && arready |=> rvalid);  // R10
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs #(
  parameter int unsigned WORD_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [7:0]        wr_byte0,
  input  logic              wr_be0,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              accel_done,
  input  logic              accel_idle,
  input  logic              accel_ready,
  output logic              accel_start,
  output logic              irq,
  output logic [DATA_W-1:0] rd_data
);
  import accel_ctrl_pkg::*;

  localparam logic [WORD_W-1:0] W_CTRL = WORD_W'(WORD_CTRL);
  localparam logic [WORD_W-1:0] W_GIE  = WORD_W'(WORD_GIE);
  localparam logic [WORD_W-1:0] W_IER  = WORD_W'(WORD_IER);
  localparam logic [WORD_W-1:0] W_ISR  = WORD_W'(WORD_ISR);

  logic     start_q, start_d;
  logic     done_q,  done_d;
  logic     auto_q,  auto_d;
  logic     gie_q,   gie_d;
  irq_vec_t ier_q,   ier_d;
  irq_vec_t isr_q,   isr_d;
  irq_vec_t isr_tog, isr_evt;
  logic     wr_b0, set_start, rd_ctrl;

  assign wr_b0     = wr_en & wr_be0;
  assign set_start = wr_b0 && (wr_word == W_CTRL) && wr_byte0[CB_START];
  assign rd_ctrl   = rd_en && (rd_word == W_CTRL);
  assign isr_tog   = (wr_b0 && (wr_word == W_ISR)) ? wr_byte0[N_IRQ_CH-1:0] : '0;
  assign isr_evt   = {accel_ready, accel_done} & ier_q;

  always_comb begin
    start_d = start_q;
    if (set_start)                           start_d = 1'b1;
    else if (start_q && accel_ready && !auto_q) start_d = 1'b0;

    done_d = accel_done | (done_q & ~rd_ctrl);

    auto_d = auto_q;
    gie_d  = gie_q;
    ier_d  = ier_q;
    if (wr_b0) begin
      if (wr_word == W_CTRL) auto_d = wr_byte0[CB_AUTO];
      if (wr_word == W_GIE)  gie_d  = wr_byte0[0];
      if (wr_word == W_IER)  ier_d  = wr_byte0[N_IRQ_CH-1:0];
    end
    isr_d = (isr_q ^ isr_tog) | isr_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      auto_q  <= 1'b0;
      gie_q   <= 1'b0;
      ier_q   <= '0;
      isr_q   <= '0;
    end else begin
      start_q <= start_d;
      done_q  <= done_d;
      auto_q  <= auto_d;
      gie_q   <= gie_d;
      ier_q   <= ier_d;
      isr_q   <= isr_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_word)
      W_CTRL: begin
        rd_data[CB_START] = start_q;
        rd_data[CB_DONE]  = done_q;
        rd_data[CB_IDLE]  = accel_idle;
        rd_data[CB_READY] = accel_ready;
        rd_data[CB_AUTO]  = auto_q;
      end
      W_GIE:   rd_data[0] = gie_q;
      W_IER:   rd_data[N_IRQ_CH-1:0] = ier_q;
      W_ISR:   rd_data[N_IRQ_CH-1:0] = isr_q;
      default: rd_data = '0;
    endcase
  end

  assign accel_start = start_q;
  assign irq         = gie_q & |(isr_q & ier_q);

  AST_START_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    accel_start && !accel_ready |=> accel_start);  // R3
  AST_AUTO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    accel_start && auto_q && accel_ready |=> accel_start);  // R5
  AST_DONE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    accel_done |=> done_q);  // R4
  AST_ISR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isr_q[0]) |-> ($past(accel_done && ier_q[0]) || $past(isr_tog[0])));  // R7
endmodule

// File: rtl/arg_regs.sv
module arg_regs #(
  parameter int unsigned NUM_ARGS = 9,
  parameter int unsigned WORD_W   = 5,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned STRB_W  = DATA_W / 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [WORD_W-1:0]          wr_word,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [STRB_W-1:0]          wr_strb,
  input  logic [WORD_W-1:0]          rd_word,
  output logic [NUM_ARGS*DATA_W-1:0] arg_flat,
  output logic [DATA_W-1:0]          rd_data
);
  import accel_ctrl_pkg::*;

  logic [NUM_ARGS-1:0][DATA_W-1:0] sel_data;

  for (genvar k = 0; k < NUM_ARGS; k++) begin : g_arg
    localparam logic [WORD_W-1:0] MY_WORD = WORD_W'(WORD_ARG0 + ARG_STEP * k);
    logic [DATA_W-1:0] val_q, val_d;
    logic              val_en;

    assign val_en = wr_en && (wr_word == MY_WORD);

    always_comb begin
      val_d = val_q;
      for (int b = 0; b < STRB_W; b++) begin
        if (wr_strb[b]) val_d[8*b +: 8] = wr_data[8*b +: 8];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      val_q <= '0;
      else if (val_en) val_q <= val_d;
    end

    assign arg_flat[k*DATA_W +: DATA_W] = val_q;
    assign sel_data[k] = (rd_word == MY_WORD) ? val_q : '0;
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_ARGS; k++) rd_data = rd_data | sel_data[k];
  end
endmodule

// File: rtl/accel_ctrl_slave.sv
module accel_ctrl_slave #(
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_ARGS = 9,
  localparam int unsigned WORD_W  = ADDR_W - 2,
  localparam int unsigned STRB_W  = DATA_W / 8
) (
  input  logic                       aclk,
  input  logic                       aresetn,
  input  logic [ADDR_W-1:0]          s_awaddr,
  input  logic                       s_awvalid,
  output logic                       s_awready,
  input  logic [DATA_W-1:0]          s_wdata,
  input  logic [STRB_W-1:0]          s_wstrb,
  input  logic                       s_wvalid,
  output logic                       s_wready,
  output logic [1:0]                 s_bresp,
  output logic                       s_bvalid,
  input  logic                       s_bready,
  input  logic [ADDR_W-1:0]          s_araddr,
  input  logic                       s_arvalid,
  output logic                       s_arready,
  output logic [DATA_W-1:0]          s_rdata,
  output logic [1:0]                 s_rresp,
  output logic                       s_rvalid,
  input  logic                       s_rready,
  output logic                       accel_start,
  input  logic                       accel_done,
  input  logic                       accel_idle,
  input  logic                       accel_ready,
  output logic                       irq,
  output logic [NUM_ARGS*DATA_W-1:0] kern_args
);
  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic              wr_en, rd_en;
  logic [WORD_W-1:0] wr_word, rd_word;
  logic [DATA_W-1:0] wr_data, ctrl_rd, arg_rd, rd_word_data;
  logic [STRB_W-1:0] wr_strb;

  // asynchronous assertion, synchronous release
  always_ff @(posedge aclk or negedge aresetn) begin
    if (!aresetn) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  axil_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(aclk), .rst_n(rst_n),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_en(rd_en), .rd_word(rd_word), .rd_word_data(rd_word_data)
  );

  ctrl_regs #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(aclk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_word(wr_word), .wr_byte0(wr_data[7:0]), .wr_be0(wr_strb[0]),
    .rd_en(rd_en), .rd_word(rd_word),
    .accel_done(accel_done), .accel_idle(accel_idle), .accel_ready(accel_ready),
    .accel_start(accel_start), .irq(irq), .rd_data(ctrl_rd)
  );

  arg_regs #(.NUM_ARGS(NUM_ARGS), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_args (
    .clk(aclk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_word(rd_word), .arg_flat(kern_args), .rd_data(arg_rd)
  );

  assign rd_word_data = ctrl_rd | arg_rd;

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge aclk) disable iff (!rst_n)
    $rose(irq) |-> !$past(s_bvalid && s_bready) || $past(wr_en) || $past(accel_done || accel_ready));  // R8
endmodule

// File: tb/accel_ctrl_slave_tb_top.sv
module accel_ctrl_slave_tb_top;
  localparam int unsigned NA = 9;

  logic        clk = 1'b0;
  logic        aresetn;
  logic [6:0]  awaddr, araddr;
  logic        awvalid, wvalid, arvalid;
  logic        awready, wready, arready;
  logic [31:0] wdata, rdata;
  logic [3:0]  wstrb;
  logic [1:0]  bresp, rresp;
  logic        bvalid, rvalid;
  logic        accel_start, accel_done, accel_idle, accel_ready, irq;
  logic [NA*32-1:0] kern_args;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;  // 250 MHz

  accel_ctrl_slave dut_i (
    .aclk(clk), .aresetn(aresetn),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(1'b1),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(1'b1),
    .accel_start(accel_start), .accel_done(accel_done),
    .accel_idle(accel_idle), .accel_ready(accel_ready),
    .irq(irq), .kern_args(kern_args)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [6:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1'b1; wvalid = 1'b1;
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0;
    chk("R10 write response", {29'd0, bvalid, bresp}, 32'h4);
    @(negedge clk);
  endtask

  // driver: pushes the expected read value, the monitor compares it
  task automatic do_read(input logic [6:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    araddr = a; arvalid = 1'b1;
    @(negedge clk);
    arvalid = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_done();
    @(negedge clk); accel_done = 1'b1;
    @(negedge clk); accel_done = 1'b0;
  endtask

  task automatic pulse_ready();
    @(negedge clk); accel_ready = 1'b1;
    @(negedge clk); accel_ready = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected read data actual=0x%08h expected=none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(t, rdata, e);
        chk("R10 read response", {30'd0, rresp}, 32'h0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    aresetn = 1'b0; awaddr = '0; araddr = '0; wdata = '0; wstrb = '0;
    awvalid = 1'b0; wvalid = 1'b0; arvalid = 1'b0;
    accel_done = 1'b0; accel_idle = 1'b0; accel_ready = 1'b0;
    repeat (3) @(negedge clk);
    aresetn = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 start", {31'd0, accel_start}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 valids", {30'd0, bvalid, rvalid}, 0);
    chk("R1 args", {31'd0, |kern_args}, 0);
    do_read(7'h00, 32'h0, "R1 ctrl");
    do_read(7'h0C, 32'h0, "R1 isr");

    // R6 live status bits
    accel_idle = 1'b1;
    do_read(7'h00, 32'h4, "R6 idle");
    accel_idle = 1'b0; accel_ready = 1'b1;
    do_read(7'h00, 32'h8, "R6 ready");
    accel_ready = 1'b0;

    // R2 arguments and strobes
    do_write(7'h10, 32'hDEADBEEF, 4'hF);
    do_read(7'h10, 32'hDEADBEEF, "R2 arg0");
    chk("R2 arg0 port", kern_args[31:0], 32'hDEADBEEF);
    do_write(7'h50, 32'h1234AB56, 4'h2);
    do_read(7'h50, 32'h0000AB00, "R2 arg8 strobe");
    chk("R2 arg8 port", kern_args[8*32 +: 32], 32'h0000AB00);
    do_write(7'h28, 32'h11223344, 4'hF);
    do_read(7'h28, 32'h11223344, "R2 arg3");
    chk("R2 arg3 port", kern_args[3*32 +: 32], 32'h11223344);

    // R9 reserved space
    do_write(7'h14, 32'hFFFFFFFF, 4'hF);
    do_read(7'h14, 32'h0, "R9 gap word");
    do_read(7'h58, 32'h0, "R9 above map");
    chk("R9 args untouched", kern_args[31:0] ^ kern_args[8*32 +: 32], 32'hDEADBEEF ^ 32'h0000AB00);
    do_write(7'h00, 32'hFFFFFF7C, 4'hF);
    do_read(7'h00, 32'h0, "R9 ctrl reserved");
    do_write(7'h04, 32'hFFFFFFFF, 4'hF);
    do_read(7'h04, 32'h1, "R9 gie bits");
    do_write(7'h08, 32'hFFFFFFFF, 4'hF);
    do_read(7'h08, 32'h3, "R9 ier bits");
    do_write(7'h08, 32'h0, 4'hF);
    do_write(7'h04, 32'h0, 4'hF);

    // R3 launch handshake
    do_write(7'h00, 32'h1, 4'h1);
    chk("R3 start set", {31'd0, accel_start}, 1);
    do_write(7'h00, 32'h0, 4'h1);
    chk("R3 zero ignored", {31'd0, accel_start}, 1);
    do_read(7'h00, 32'h1, "R3 start readback");
    pulse_ready();
    chk("R3 start cleared", {31'd0, accel_start}, 0);

    // R4 sticky completion flag
    pulse_done();
    do_read(7'h00, 32'h2, "R4 done set");
    do_read(7'h00, 32'h0, "R4 done cleared");
    @(negedge clk);
    exp_q.push_back(32'h0); tag_q.push_back("R4 same cycle read");
    araddr = 7'h00; arvalid = 1'b1; accel_done = 1'b1;
    @(negedge clk);
    arvalid = 1'b0; accel_done = 1'b0;
    @(negedge clk);
    do_read(7'h00, 32'h2, "R4 set wins");
    do_read(7'h00, 32'h0, "R4 cleared after");

    // R5 relaunch
    do_write(7'h00, 32'h81, 4'h1);
    pulse_ready();
    chk("R5 start held", {31'd0, accel_start}, 1);
    do_read(7'h00, 32'h81, "R5 readback");
    do_write(7'h00, 32'h00, 4'h1);
    do_read(7'h00, 32'h01, "R5 flag off");
    pulse_ready();
    chk("R5 start drops", {31'd0, accel_start}, 0);

    // R7 / R8 interrupts
    pulse_done();
    do_read(7'h0C, 32'h0, "R7 masked event");
    do_read(7'h00, 32'h2, "R4 done before irq test");
    do_write(7'h08, 32'h1, 4'h1);
    do_write(7'h04, 32'h1, 4'h1);
    chk("R8 irq idle", {31'd0, irq}, 0);
    pulse_done();
    chk("R8 irq on done", {31'd0, irq}, 1);
    do_read(7'h0C, 32'h1, "R7 event set");
    do_write(7'h0C, 32'h1, 4'h1);
    do_read(7'h0C, 32'h0, "R7 toggle clear");
    chk("R8 irq cleared", {31'd0, irq}, 0);
    do_write(7'h0C, 32'h2, 4'h1);
    do_read(7'h0C, 32'h2, "R7 toggle set");
    chk("R8 masked channel", {31'd0, irq}, 0);
    do_write(7'h0C, 32'h2, 4'h0);
    do_read(7'h0C, 32'h2, "R7 no strobe");
    do_write(7'h08, 32'h3, 4'h1);
    chk("R8 enable channel", {31'd0, irq}, 1);
    do_write(7'h04, 32'h0, 4'h1);
    chk("R8 global off", {31'd0, irq}, 0);

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R10 missing read data actual=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule